// File: doc/BRIEF.md
# Two-Step Addressed DRAM Subsystem

This block is a small behavioural DRAM subsystem: a controller in front of a 128-bit storage grid of 4 rows by 4 columns, each cell 8 bits wide. A client issues a 4-bit linear cell address, a read/write flag and write data through a valid/ready request port. The controller splits the address into a row index (upper two bits) and a column index (lower two bits). It sends them one after the other over one shared 2-bit address bus, with a row strobe first and a column strobe later.

On the row strobe the grid copies the selected row into a row buffer. The column strobe picks one cell out of that buffer. A write updates the buffer, and a read returns the cell's old contents. A precharge cycle then writes the buffer back into the grid. A refresh timer asks for a refresh at a fixed period. Between user accesses the controller opens and closes one row at a time, walking the rows in round-robin order, so that every stored value is reread and rewritten.

Back-pressure rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle and no refresh is waiting. The request fields are ignored while `req_ready` is low. A client that sees `req_ready` low may hold or withdraw its request. The read-data port has no back-pressure: `rd_valid` is a one-cycle pulse that the client must take.

Top module: `mux_dram_sys`

## Requirements
- R1: Reset clears every cell to zero, returns the controller to idle with `req_ready` high and `rd_valid` low, and restarts the refresh row sequence at row 0.
- R2: A write stores `req_wdata` at cell `req_addr`, and a later read of the same address returns it. `req_addr[3:2]` is the row and `req_addr[1:0]` is the column.
- R3: Each user access drives the row index on `dram_addr` together with `row_strobe`, and later drives the column index on `dram_addr` together with `col_strobe`. The two strobes are never high in the same cycle.
- R4: At least one cycle without either strobe separates a row strobe from the next column strobe.
- R5: `req_ready` is low from the accepting edge until the access finishes. Request inputs presented while `req_ready` is low have no effect on the stored data.
- R6: A read gives a single-cycle `rd_valid` pulse with the cell value on `rd_data` in the 4th cycle after the accepting edge. A write gives no `rd_valid`.
- R7: With no user traffic, refresh row strobes (`refresh_active` high) occur exactly `REFRESH_PERIOD` cycles apart. The default period is 64.
- R8: Successive refreshes drive the row indices 0, 1, 2, 3, 0, ... on `dram_addr`.
- R9: `req_ready` is low during a refresh, and stored contents are unchanged by any number of refreshes.
- R10: Writing one cell leaves the other cells of the same row unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Linear cell address: row in [3:2], column in [1:0] |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse, read data present |
| rd_data | output | 8 | Read data |
| dram_addr | output | 2 | Shared row/column address bus |
| row_strobe | output | 1 | Row index on `dram_addr` is valid; open that row |
| col_strobe | output | 1 | Column index on `dram_addr` is valid; transfer one cell |
| refresh_active | output | 1 | Current row strobe belongs to a refresh |

## Verification
The properties assume that request inputs change only away from the rising edge, and that the first edge after reset finds the controller idle with both strobes low. The bench changes all inputs on falling edges and releases reset on a falling edge. It withdraws a request that it drove while `req_ready` was low before the controller returns to idle, so that the R5 check can show those inputs had no effect. User accesses run while the refresh timer keeps firing. The refresh period is measured only in a window with no traffic, where the interval is exact.

// File: rtl/dram_pkg.sv
package dram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_DATA,
    ST_PRE,
    ST_REF
  } ctrl_state_e;

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int PERIOD = 64,
  parameter int ROW_AW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack,
  output logic              pending,
  output logic [ROW_AW-1:0] next_row
);

  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] tick_cnt;
  logic          tick;

  assign tick = (tick_cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
    end else if (tick) begin
      tick_cnt <= '0;
    end else begin
      tick_cnt <= tick_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else begin
      pending <= tick | (pending & ~ack);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_row <= '0;
    end else if (ack) begin
      next_row <= next_row + 1'b1;
    end
  end

endmodule

// File: rtl/dram_array.sv
module dram_array #(
  parameter int CELL_W = 8,
  parameter int ROW_AW = 2,
  parameter int COL_AW = 2,
  parameter int BUS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  bus_addr,
  input  logic              row_stb,
  input  logic              col_stb,
  input  logic              col_we,
  input  logic [CELL_W-1:0] col_wdata,
  input  logic              precharge,
  output logic [CELL_W-1:0] rdata
);

  localparam int ROWS = 1 << ROW_AW;
  localparam int COLS = 1 << COL_AW;

  typedef logic [COLS-1:0][CELL_W-1:0] row_t;

  row_t              row_view [ROWS];
  row_t              rbuf;
  logic [ROW_AW-1:0] open_row;
  logic [ROW_AW-1:0] row_sel;
  logic [COL_AW-1:0] col_sel;

  assign row_sel = bus_addr[ROW_AW-1:0];
  assign col_sel = bus_addr[COL_AW-1:0];

  // One register bank per row; written back only on precharge of that row.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    row_t cells_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cells_q <= '0;
      end else if (precharge && (open_row == ROW_AW'(r))) begin
        cells_q <= rbuf;
      end
    end

    assign row_view[r] = cells_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf     <= '0;
      open_row <= '0;
    end else if (row_stb) begin
      rbuf     <= row_view[row_sel];
      open_row <= row_sel;
    end else if (col_stb && col_we) begin
      rbuf[col_sel] <= col_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (col_stb) begin
      rdata <= rbuf[col_sel];
    end
  end

endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
  import dram_pkg::*;
#(
  parameter int CELL_W = 8,
  parameter int ROW_AW = 2,
  parameter int COL_AW = 2,
  parameter int BUS_W  = 2,
  parameter int GAP    = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ROW_AW+COL_AW-1:0] req_addr,
  input  logic [CELL_W-1:0]        req_wdata,
  input  logic                     ref_pending,
  input  logic [ROW_AW-1:0]        ref_row,
  output logic                     ref_ack,
  output logic [BUS_W-1:0]         bus_addr,
  output logic                     row_stb,
  output logic                     col_stb,
  output logic                     col_we,
  output logic [CELL_W-1:0]        col_wdata,
  output logic                     precharge,
  output logic                     rd_valid,
  output logic                     refresh_active
);

  localparam int ADDR_W = ROW_AW + COL_AW;
  localparam int GW     = $clog2(GAP + 1);

  ctrl_state_e       state;
  logic [ROW_AW-1:0] row_q;
  logic [COL_AW-1:0] col_q;
  logic              we_q;
  logic [CELL_W-1:0] wdata_q;
  logic [GW-1:0]     gap_cnt;
  logic              accept;

  assign req_ready = (state == ST_IDLE) && !ref_pending;
  assign ref_ack   = (state == ST_IDLE) && ref_pending;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      gap_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          gap_cnt <= '0;
          if (ref_pending) begin
            row_q <= ref_row;
            state <= ST_REF;
          end else if (accept) begin
            row_q   <= req_addr[ADDR_W-1 -: ROW_AW];
            col_q   <= req_addr[COL_AW-1:0];
            we_q    <= req_write;
            wdata_q <= req_wdata;
            state   <= ST_ROW;
          end
        end
        ST_ROW: begin
          if (gap_cnt == GW'(GAP)) begin
            state <= ST_COL;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        ST_COL:  state <= ST_DATA;
        ST_DATA: state <= ST_PRE;
        ST_REF:  state <= ST_PRE;
        ST_PRE:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_addr = '0;
    if (state == ST_ROW || state == ST_REF) begin
      bus_addr = BUS_W'(row_q);
    end else if (state == ST_COL) begin
      bus_addr = BUS_W'(col_q);
    end
  end

  assign row_stb        = ((state == ST_ROW) && (gap_cnt == '0)) || (state == ST_REF);
  assign col_stb        = (state == ST_COL);
  assign col_we         = we_q;
  assign col_wdata      = wdata_q;
  assign precharge      = (state == ST_PRE);
  assign rd_valid       = (state == ST_DATA) && !we_q;
  assign refresh_active = (state == ST_REF);

endmodule

// File: rtl/mux_dram_sys.sv
module mux_dram_sys #(
  parameter int CELL_W         = 8,
  parameter int ROW_AW         = 2,
  parameter int COL_AW         = 2,
  parameter int REFRESH_PERIOD = 64,
  parameter int GAP            = 1
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        req_valid,
  output logic                                        req_ready,
  input  logic                                        req_write,
  input  logic [ROW_AW+COL_AW-1:0]                    req_addr,
  input  logic [CELL_W-1:0]                           req_wdata,
  output logic                                        rd_valid,
  output logic [CELL_W-1:0]                           rd_data,
  output logic [((ROW_AW > COL_AW) ? ROW_AW : COL_AW)-1:0] dram_addr,
  output logic                                        row_strobe,
  output logic                                        col_strobe,
  output logic                                        refresh_active
);

  localparam int BUS_W = (ROW_AW > COL_AW) ? ROW_AW : COL_AW;

  logic              ref_pending;
  logic              ref_ack;
  logic [ROW_AW-1:0] ref_row;
  logic              col_we;
  logic [CELL_W-1:0] col_wdata;
  logic              precharge;

  dram_refresh_timer #(
    .PERIOD (REFRESH_PERIOD),
    .ROW_AW (ROW_AW)
  ) u_refresh (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack      (ref_ack),
    .pending  (ref_pending),
    .next_row (ref_row)
  );

  dram_ctrl #(
    .CELL_W (CELL_W),
    .ROW_AW (ROW_AW),
    .COL_AW (COL_AW),
    .BUS_W  (BUS_W),
    .GAP    (GAP)
  ) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_write      (req_write),
    .req_addr       (req_addr),
    .req_wdata      (req_wdata),
    .ref_pending    (ref_pending),
    .ref_row        (ref_row),
    .ref_ack        (ref_ack),
    .bus_addr       (dram_addr),
    .row_stb        (row_strobe),
    .col_stb        (col_strobe),
    .col_we         (col_we),
    .col_wdata      (col_wdata),
    .precharge      (precharge),
    .rd_valid       (rd_valid),
    .refresh_active (refresh_active)
  );

  dram_array #(
    .CELL_W (CELL_W),
    .ROW_AW (ROW_AW),
    .COL_AW (COL_AW),
    .BUS_W  (BUS_W)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (dram_addr),
    .row_stb   (row_strobe),
    .col_stb   (col_strobe),
    .col_we    (col_we),
    .col_wdata (col_wdata),
    .precharge (precharge),
    .rdata     (rd_data)
  );

endmodule

// File: rtl/mux_dram_sys_chk.sv
module mux_dram_sys_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rd_valid,
  input logic row_strobe,
  input logic col_strobe,
  input logic refresh_active
);

  // R3: the shared bus never carries a row and a column strobe together
  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(row_strobe && col_strobe));

  // R3: an accepted request opens its row on the next cycle
  a_r3_accept_opens_row: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> row_strobe);

  // R4: a column strobe never directly follows a row strobe
  a_r4_gap_before_col: assert property (@(posedge clk) disable iff (!rst_n)
    col_strobe |-> !$past(row_strobe));

  // R5: no new request is taken while a row is being opened or a column moved
  a_r5_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (row_strobe || col_strobe) |-> !req_ready);

  // R6: read data valid lasts one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R9: a refresh blocks the request port
  a_r9_refresh_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_active |-> !req_ready);

endmodule

bind mux_dram_sys mux_dram_sys_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .rd_valid       (rd_valid),
  .row_strobe     (row_strobe),
  .col_strobe     (col_strobe),
  .refresh_active (refresh_active)
);

// File: tb/mux_dram_sys_tb.sv
module mux_dram_sys_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PERIOD     = 64;
  localparam int RD_LAT     = 4;
  localparam int NVEC       = 18;

  // {write, addr[3:0], data[7:0]}; for reads data is the expected value
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b1, 4'h0, 8'hA5}, {1'b1, 4'h3, 8'h3C}, {1'b1, 4'h5, 8'h11},
    {1'b1, 4'hA, 8'hFF}, {1'b1, 4'hF, 8'h80}, {1'b1, 4'hC, 8'h01},
    {1'b1, 4'h9, 8'h77},
    {1'b0, 4'h0, 8'hA5}, {1'b0, 4'h3, 8'h3C}, {1'b0, 4'h1, 8'h00},
    {1'b0, 4'h5, 8'h11}, {1'b0, 4'hA, 8'hFF}, {1'b0, 4'h9, 8'h77},
    {1'b0, 4'hF, 8'h80}, {1'b0, 4'hC, 8'h01},
    {1'b1, 4'h5, 8'h22}, {1'b0, 4'h4, 8'h00}, {1'b0, 4'h5, 8'h22}
  };

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic       req_ready;
  logic       req_write;
  logic [3:0] req_addr;
  logic [7:0] req_wdata;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic [1:0] dram_addr;
  logic       row_strobe;
  logic       col_strobe;
  logic       refresh_active;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  logic [3:0] cur_addr = '0;
  int  last_row_cyc = 0;
  int  last_ref_cyc = -1;
  bit  gap_on = 1'b0;
  logic [1:0] ref_exp = '0;

  mux_dram_sys #(.REFRESH_PERIOD(PERIOD)) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_write      (req_write),
    .req_addr       (req_addr),
    .req_wdata      (req_wdata),
    .rd_valid       (rd_valid),
    .rd_data        (rd_data),
    .dram_addr      (dram_addr),
    .row_strobe     (row_strobe),
    .col_strobe     (col_strobe),
    .refresh_active (refresh_active)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Bus and refresh monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      ref_exp = '0;
    end else begin
      if (row_strobe && !refresh_active) begin
        check(dram_addr == cur_addr[3:2], "R3 row index", dram_addr, cur_addr[3:2]);
        last_row_cyc = cyc;
      end
      if (col_strobe) begin
        check(dram_addr == cur_addr[1:0], "R3 column index", dram_addr, cur_addr[1:0]);
        check(cyc - last_row_cyc >= 2, "R4 strobe gap", cyc - last_row_cyc, 2);
      end
      if (refresh_active) begin
        check(dram_addr == ref_exp, "R8 refresh row", dram_addr, ref_exp);
        check(!req_ready, "R9 ready during refresh", req_ready, 0);
        if (gap_on && last_ref_cyc >= 0)
          check(cyc - last_ref_cyc == PERIOD, "R7 refresh interval", cyc - last_ref_cyc, PERIOD);
        last_ref_cyc = cyc;
        ref_exp = ref_exp + 2'd1;
      end
    end
  end

  task automatic access(input bit we, input logic [3:0] a, input logic [7:0] d,
                        output logic [7:0] got, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_addr  = a;
    req_valid = 1'b1;
    req_write = we;
    req_addr  = a;
    req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    got = '0;
    for (int k = 1; k <= 6; k++) begin
      if (k > 1) @(negedge clk);
      if (rd_valid) begin
        if (lat == 0) begin
          lat = k;
          got = rd_data;
        end else begin
          lat = 99;
        end
      end
    end
  endtask

  task automatic do_read(input logic [3:0] a, input logic [7:0] exp, input string req);
    logic [7:0] got;
    int lat;
    access(1'b0, a, 8'h00, got, lat);
    check(got == exp, req, got, exp);
    check(lat == RD_LAT, "R6 read latency", lat, RD_LAT);
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] got;
    int lat;
    access(1'b1, a, d, got, lat);
    check(lat == 0, "R6 no pulse on write", lat, 0);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    last_ref_cyc = -1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    check(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);

    // Vector table (R2, R6, R10)
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][12])
        do_write(VEC[i][11:8], VEC[i][7:0]);
      else
        do_read(VEC[i][11:8], VEC[i][7:0], "R2 table read");
    end

    // R10: neighbours in a written row keep their values
    do_write(4'h6, 8'h5A);
    do_read(4'h7, 8'h00, "R10 neighbour column");
    do_read(4'h4, 8'h00, "R10 neighbour column");
    do_read(4'h5, 8'h22, "R10 neighbour column");

    // R5: inputs while ready is low are ignored
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_addr  = 4'h6;
    req_valid = 1'b1;
    req_write = 1'b0;
    req_addr  = 4'h6;
    @(posedge clk);
    @(negedge clk);
    check(req_ready == 1'b0, "R5 ready low while busy", req_ready, 0);
    req_write = 1'b1;
    req_wdata = 8'hEE;
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    do_read(4'h6, 8'h5A, "R5 busy inputs ignored");

    // R7/R8/R9: idle window, refresh interval and contents preserved
    @(negedge clk);
    last_ref_cyc = -1;
    gap_on = 1'b1;
    repeat (PERIOD * 6) @(negedge clk);
    gap_on = 1'b0;
    do_read(4'h0, 8'hA5, "R9 survives refresh");
    do_read(4'hA, 8'hFF, "R9 survives refresh");
    do_read(4'hF, 8'h80, "R9 survives refresh");

    // R1: reset clears the stored cells
    apply_reset();
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after second reset", req_ready, 1);
    for (int a = 0; a < 16; a++) begin
      do_read(4'(a), 8'h00, "R1 cleared cell");
    end

    // R8: sequence restarts at row 0 after reset
    @(negedge clk);
    last_ref_cyc = -1;
    gap_on = 1'b1;
    repeat (PERIOD * 3) @(negedge clk);
    gap_on = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule